// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block stores the on/off state of each switch in a crosspoint array of 12 rows by 8 columns, 96 state bits in all. A write selects one bit with a 7-bit address made of a column field and a row code, and it carries one data bit. The write is qualified by a strobe. A system clock samples the strobe level at each rising edge. While the strobe is high, the addressed bit takes the data value at every edge, so the switch follows the data for as long as the strobe stays high. Once the strobe falls, the bit keeps the data value from the last edge at which the strobe was high.

The row code space is sparse. It has two banks of six rows, and the two spare codes at the top of each bank select no switch. An active-high reset clears every bit at once, with no clock edge needed. The block drives a 96-bit vector of switch enables, one bit per crosspoint. A 1 means the switch is closed and a 0 means it is open.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: The column is `addr_i[2:0]` and the row code is `addr_i[6:3]`. Switch (row, column) drives `sw_en_o[row*8 + column]`.
- R2: Row codes 0 to 5 select rows 0 to 5. Row codes 8 to 13 select rows 6 to 11.
- R3: A strobed write with row code 6, 7, 14 or 15 leaves all 96 bits of `sw_en_o` unchanged.
- R4: At every rising clock edge with `strobe_i` high, the addressed bit takes `data_i`. The new value shows on `sw_en_o` after that same edge. Toggling `data_i` on successive cycles while the strobe is high toggles the switch with it.
- R5: After the strobe falls, the addressed bit holds the data sampled at the last edge at which the strobe was high. Edges with `strobe_i` low change no bit, whatever `addr_i` and `data_i` do.
- R6: A write changes only the addressed bit. All other bits keep their earlier values.
- R7: A high `rst_i` clears all 96 bits to 0 at once, without waiting for a clock edge.
- R8: While `rst_i` is high, strobe activity has no effect and all bits stay 0.
- R9: After reset is released and before the first write, `sw_en_o` reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; the strobe is sampled on its rising edge |
| rst_i | input | 1 | Asynchronous clear, active high |
| strobe_i | input | 1 | Write qualifier, sampled as a level |
| addr_i | input | 7 | Column field in bits 2:0, row code in bits 6:3 |
| data_i | input | 1 | Value for the addressed switch; 1 closes it |
| sw_en_o | output | 96 | Switch enables, indexed row*8 + column |

## Verification
Two situations are hard to reach from the ports. The first is a strobe held high across several edges while the data toggles, followed by a fall that must freeze the last sampled value. The second is the same strobe activity arriving while reset is held. The bench holds the strobe high over consecutive edges with alternating data and checks the output after each edge. It then drops the strobe and moves the address and data, to show that nothing else changes. It also raises reset between clock edges and checks that the vector is already clear before the next edge. Finally it strobes a write of 1 while reset is high, releases reset, and checks that no bit is set.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

   // Default geometry of the crosspoint control store
   localparam int unsigned XPT_COL_BITS      = 3;
   localparam int unsigned XPT_SLOT_BITS     = 3;
   localparam int unsigned XPT_BANKS         = 2;
   localparam int unsigned XPT_ROWS_PER_BANK = 6;

   // Field widths at or below zero are raised to one so that vectors stay legal
   function automatic int unsigned xpt_w(input int unsigned n);
      return (n < 1) ? 1 : n;
   endfunction

endpackage

// File: rtl/xpt_addr_decode.sv
module xpt_addr_decode #(
   parameter int unsigned COL_BITS      = xpt_pkg::XPT_COL_BITS,
   parameter int unsigned SLOT_BITS     = xpt_pkg::XPT_SLOT_BITS,
   parameter int unsigned BANKS         = xpt_pkg::XPT_BANKS,
   parameter int unsigned ROWS_PER_BANK = xpt_pkg::XPT_ROWS_PER_BANK,
   localparam int unsigned BANK_BITS    = (BANKS > 1) ? $clog2(BANKS) : 0,
   localparam int unsigned CODE_BITS    = BANK_BITS + SLOT_BITS,
   localparam int unsigned ADDR_W       = COL_BITS + CODE_BITS,
   localparam int unsigned ROWS         = BANKS * ROWS_PER_BANK,
   localparam int unsigned ROW_W        = xpt_pkg::xpt_w($clog2(ROWS))
) (
   input  logic [ADDR_W-1:0]   addr_i,
   output logic                valid_o,
   output logic [ROW_W-1:0]    row_o,
   output logic [COL_BITS-1:0] col_o
);

   logic [SLOT_BITS-1:0] slot;
   logic                 slot_ok;

   assign col_o   = addr_i[COL_BITS-1:0];
   assign slot    = addr_i[COL_BITS +: SLOT_BITS];
   assign slot_ok = (int'(slot) < ROWS_PER_BANK);

   if (ROWS_PER_BANK > (2 ** SLOT_BITS)) begin : g_bad_slot
      $error("xpt_addr_decode: a bank holds more rows than its slot field can encode");
   end

   if (BANKS > 1) begin : g_banked
      logic [BANK_BITS-1:0] bank;
      logic                 bank_ok;
      assign bank    = addr_i[COL_BITS+SLOT_BITS +: BANK_BITS];
      assign bank_ok = (int'(bank) < BANKS);
      assign valid_o = slot_ok && bank_ok;
      assign row_o   = ROW_W'(int'(bank) * ROWS_PER_BANK + int'(slot));
   end else begin : g_single
      assign valid_o = slot_ok;
      assign row_o   = ROW_W'(slot);
   end

endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array #(
   parameter int unsigned ROWS     = 12,
   parameter int unsigned COL_BITS = 3,
   localparam int unsigned COLS    = 2 ** COL_BITS,
   localparam int unsigned CELLS   = ROWS * COLS,
   localparam int unsigned ROW_W   = xpt_pkg::xpt_w($clog2(ROWS)),
   localparam int unsigned IDX_W   = xpt_pkg::xpt_w($clog2(CELLS))
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                we_i,
   input  logic [ROW_W-1:0]    row_i,
   input  logic [COL_BITS-1:0] col_i,
   input  logic                data_i,
   output logic [CELLS-1:0]    state_o
);

   logic [IDX_W-1:0] wr_idx;
   assign wr_idx = IDX_W'(int'(row_i) * COLS + int'(col_i));

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic row_hit;
      assign row_hit = we_i && (int'(row_i) == r);
      for (genvar c = 0; c < COLS; c++) begin : g_col
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) begin
               state_o[r*COLS+c] <= 1'b0;
            end else if (row_hit && (int'(col_i) == c)) begin
               state_o[r*COLS+c] <= data_i;
            end
         end
      end
   end

   // R4
   write_track_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      we_i |=> (state_o[$past(wr_idx)] == $past(data_i)));

   // R6
   single_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> ($countones(state_o ^ $past(state_o)) <= 1));

   // R7
   always @(posedge clk_i) begin
      if (rst_i) begin
         reset_clear_chk: assert (state_o == '0);
      end
   end

endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem #(
   parameter int unsigned COL_BITS      = xpt_pkg::XPT_COL_BITS,
   parameter int unsigned SLOT_BITS     = xpt_pkg::XPT_SLOT_BITS,
   parameter int unsigned BANKS         = xpt_pkg::XPT_BANKS,
   parameter int unsigned ROWS_PER_BANK = xpt_pkg::XPT_ROWS_PER_BANK,
   localparam int unsigned BANK_BITS    = (BANKS > 1) ? $clog2(BANKS) : 0,
   localparam int unsigned ADDR_W       = COL_BITS + BANK_BITS + SLOT_BITS,
   localparam int unsigned ROWS         = BANKS * ROWS_PER_BANK,
   localparam int unsigned CELLS        = ROWS * (2 ** COL_BITS),
   localparam int unsigned ROW_W        = xpt_pkg::xpt_w($clog2(ROWS))
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              strobe_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              data_i,
   output logic [CELLS-1:0]  sw_en_o
);

   logic                addr_ok;
   logic [ROW_W-1:0]    wr_row;
   logic [COL_BITS-1:0] wr_col;
   logic                wr_en;

   if (COL_BITS < 1 || SLOT_BITS < 1 || BANKS < 1 || ROWS_PER_BANK < 1) begin : g_bad_geom
      $error("xpt_ctrl_mem: every geometry parameter must be at least one");
   end

   xpt_addr_decode #(
      .COL_BITS      (COL_BITS),
      .SLOT_BITS     (SLOT_BITS),
      .BANKS         (BANKS),
      .ROWS_PER_BANK (ROWS_PER_BANK)
   ) decode_i (
      .addr_i  (addr_i),
      .valid_o (addr_ok),
      .row_o   (wr_row),
      .col_o   (wr_col)
   );

   assign wr_en = strobe_i && addr_ok;

   xpt_cell_array #(
      .ROWS     (ROWS),
      .COL_BITS (COL_BITS)
   ) cells_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .we_i    (wr_en),
      .row_i   (wr_row),
      .col_i   (wr_col),
      .data_i  (data_i),
      .state_o (sw_en_o)
   );

   // R3
   spare_code_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (strobe_i && !addr_ok) |=> $stable(sw_en_o));

   // R5
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !strobe_i |=> $stable(sw_en_o));

   // R2
   row_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      addr_ok |-> (int'(wr_row) < ROWS));

endmodule

// File: tb/xpt_ctrl_mem_tb.sv
module xpt_ctrl_mem_tb_top;

   logic        clk_i    = 1'b0;
   logic        rst_i    = 1'b0;
   logic        strobe_i = 1'b0;
   logic [6:0]  addr_i   = '0;
   logic        data_i   = 1'b0;
   logic [95:0] sw_en_o;

   logic [95:0] exp_q = '0;
   int          n_checks = 0;
   int          n_fails  = 0;
   bit          done     = 1'b0;

   always #2 clk_i = ~clk_i;

   xpt_ctrl_mem dut_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .strobe_i (strobe_i),
      .addr_i   (addr_i),
      .data_i   (data_i),
      .sw_en_o  (sw_en_o)
   );

   function automatic bit code_ok(input logic [3:0] code);
      return (code[2:0] < 3'd6);
   endfunction

   function automatic int bit_of(input logic [3:0] code, input logic [2:0] col);
      return (int'(code[3]) * 6 + int'(code[2:0])) * 8 + int'(col);
   endfunction

   task automatic check_vec(input string req);
      n_checks++;
      if (sw_en_o !== exp_q) begin
         n_fails++;
         $display("FAIL %s: sw_en_o=%h expected=%h", req, sw_en_o, exp_q);
      end
   endtask

   task automatic check_bit(input string req, input int idx, input logic v);
      n_checks++;
      if (sw_en_o[idx] !== v) begin
         n_fails++;
         $display("FAIL %s: sw_en_o[%0d]=%b expected=%b", req, idx, sw_en_o[idx], v);
      end
   endtask

   // One clock cycle of stimulus; the model updates after the edge
   task automatic step(input logic s, input logic [3:0] code, input logic [2:0] col,
                       input logic d);
      @(negedge clk_i);
      strobe_i = s;
      addr_i   = {code, col};
      data_i   = d;
      @(posedge clk_i);
      #1;
      if (rst_i) exp_q = '0;
      else if (s && code_ok(code)) exp_q[bit_of(code, col)] = d;
   endtask

   task automatic write(input logic [3:0] code, input logic [2:0] col, input logic d);
      step(1'b1, code, col, d);
      step(1'b0, code, col, d);
   endtask

   task automatic do_reset();
      @(negedge clk_i);
      rst_i = 1'b1;
      exp_q = '0;
      repeat (2) @(negedge clk_i);
      rst_i = 1'b0;
   endtask

   task automatic t_reset_state();
      #1 rst_i = 1'b1;
      exp_q = '0;
      repeat (3) @(negedge clk_i);
      rst_i = 1'b0;
      step(1'b0, 4'd0, 3'd0, 1'b0);
      check_vec("R9");
   endtask

   task automatic t_mapping();
      logic [3:0] codes [5] = '{4'd0, 4'd5, 4'd8, 4'd13, 4'd3};
      logic [2:0] cols  [5] = '{3'd0, 3'd7, 3'd0, 3'd7, 3'd2};
      int         idxs  [5] = '{0, 47, 48, 95, 26};
      for (int i = 0; i < 5; i++) begin
         write(codes[i], cols[i], 1'b1);
         check_bit("R1", idxs[i], 1'b1);
         check_vec("R2");
         write(codes[i], cols[i], 1'b0);
         check_bit("R2", idxs[i], 1'b0);
      end
   endtask

   task automatic t_spare_codes();
      logic [3:0] spare [4] = '{4'd6, 4'd7, 4'd14, 4'd15};
      write(4'd2, 3'd4, 1'b1);
      write(4'd9, 3'd1, 1'b1);
      for (int i = 0; i < 4; i++) begin
         for (int c = 0; c < 8; c++) begin
            step(1'b1, spare[i], 3'(c), 1'b1);
            check_vec("R3");
         end
         step(1'b0, spare[i], 3'd0, 1'b0);
      end
   endtask

   task automatic t_transparent();
      step(1'b1, 4'd10, 3'd5, 1'b1);
      check_bit("R4", 69, 1'b1);
      step(1'b1, 4'd10, 3'd5, 1'b0);
      check_bit("R4", 69, 1'b0);
      step(1'b1, 4'd10, 3'd5, 1'b1);
      check_bit("R4", 69, 1'b1);
      check_vec("R4");
   endtask

   task automatic t_hold_after_fall();
      // strobe still high from t_transparent; last high-strobe edge writes 0
      step(1'b1, 4'd10, 3'd5, 1'b0);
      step(1'b0, 4'd10, 3'd5, 1'b1);
      check_bit("R5", 69, 1'b0);
      step(1'b0, 4'd1, 3'd3, 1'b1);
      step(1'b0, 4'd12, 3'd6, 1'b1);
      check_vec("R5");
      step(1'b1, 4'd10, 3'd5, 1'b1);
      step(1'b0, 4'd10, 3'd5, 1'b0);
      check_bit("R5", 69, 1'b1);
   endtask

   task automatic t_isolation();
      for (int r = 0; r < 16; r++) begin
         if (code_ok(4'(r))) write(4'(r), 3'(r % 8), 1'b1);
      end
      write(4'd4, 3'd0, 1'b1);
      check_vec("R6");
      write(4'd4, 3'd4, 1'b0);
      check_vec("R6");
      write(4'd11, 3'd3, 1'b1);
      check_vec("R6");
   endtask

   task automatic t_async_reset();
      write(4'd0, 3'd1, 1'b1);
      @(negedge clk_i);
      #0.5 rst_i = 1'b1;
      exp_q = '0;
      #0.5;
      check_vec("R7");
      @(negedge clk_i);
      rst_i = 1'b0;
      check_vec("R7");
   endtask

   task automatic t_reset_priority();
      @(negedge clk_i);
      rst_i = 1'b1;
      exp_q = '0;
      step(1'b1, 4'd3, 3'd3, 1'b1);
      step(1'b1, 4'd13, 3'd0, 1'b1);
      check_vec("R8");
      @(negedge clk_i);
      strobe_i = 1'b0;
      rst_i    = 1'b0;
      step(1'b0, 4'd3, 3'd3, 1'b1);
      check_vec("R8");
      do_reset();
      step(1'b0, 4'd0, 3'd0, 1'b0);
      check_vec("R9");
   endtask

   initial begin
      t_reset_state();
      t_mapping();
      t_spare_codes();
      t_transparent();
      t_hold_after_fall();
      t_isolation();
      t_async_reset();
      t_reset_priority();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk_i);
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         end
      join_any
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule